// File: doc/BRIEF.md
# Bank-Switching Memory Management Unit

This block sits between a CPU with a 16-bit logical address bus and a 21-bit physical memory system. The 64 KB logical space is cut into eight 8 KB windows. Each window owns an 8-bit block register that names one of 256 physical 8 KB blocks. The physical address is that block number placed above the low 13 logical address bits. Software remaps a window by storing a new block number into its register. The registers live at logical addresses 0x0008 to 0x000F, where window n's register sits at 0x0008 + n.

The translated address is also decoded against a fixed physical map: RAM, flash, an expansion area, and a reserved tail. Select and write-strobe outputs go only to the region being addressed. The block answers accesses to its own registers and accesses to reserved space itself, and it flags reserved accesses. Translation and decode are combinational. A register write updates state on the clock edge.

Top module: `bank_mmu`

## Requirements
- R1: After reset, window n holds block n, so every logical address maps to the same physical address, and reading register 0x0008 + n returns n.
- R2: The physical address equals {block register of window addr[15:13], addr[12:0]} in every cycle.
- R3: A write at 0x0008 + n stores the low 8 data bits into window n's register on the clock edge. A read there returns the stored value. Accesses from the next cycle on use the new block.
- R4: An access to 0x0008 through 0x000F asserts reg_hit_o and asserts no region select, no write strobe and no reserved flag.
- R5: Physical blocks 0x00 to 0x3F (addresses 0x000000 to 0x07FFFF) assert ram_sel_o during an access.
- R6: Blocks 0x40 to 0x7F (0x080000 to 0x0FFFFF) assert flash_sel_o. Blocks 0x80 to 0x9F (0x100000 to 0x13FFFF) assert exp_sel_o.
- R7: Blocks 0xA0 to 0xFF (0x140000 to 0x1FFFFF) assert no select and assert rsvd_o during an access. A read returns 0xFF.
- R8: A write strobe asserts only together with wr_i and its own region's select. At most one of the three selects and rsvd_o is high at a time.
- R9: With rd_i and wr_i both low, no select, no strobe, no reg_hit_o and no rsvd_o asserts.
- R10: A read that selects RAM, flash or expansion returns mem_rdata_i on rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU logical address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| mem_rdata_i | input | 8 | Read data returned by the selected memory |
| rdata_o | output | 8 | Read data to the CPU |
| phys_addr_o | output | 21 | Translated physical address |
| ram_sel_o | output | 1 | RAM select |
| flash_sel_o | output | 1 | Flash select |
| exp_sel_o | output | 1 | Expansion memory select |
| ram_we_o | output | 1 | RAM write strobe |
| flash_we_o | output | 1 | Flash write strobe |
| exp_we_o | output | 1 | Expansion write strobe |
| rsvd_o | output | 1 | Access to reserved physical space |
| reg_hit_o | output | 1 | Access served by the block registers |

## Verification
The bench builds the block with its default parameters: a 16-bit logical bus, eight windows, 8-bit block numbers, and region limits at blocks 64, 128 and 160. With 8-bit block numbers, a random store can reach every region boundary (0x3F/0x40, 0x7F/0x80, 0x9F/0xA0). About a quarter of the random accesses are steered into the eight-byte register window, so remapping happens often. Directed cases place a remapped window on each side of every boundary. They also touch window 0, where ordinary memory sits next to the register window.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    RGN_RAM   = 2'd0,
    RGN_FLASH = 2'd1,
    RGN_EXP   = 2'd2,
    RGN_RSVD  = 2'd3
  } region_e;
endpackage

// File: rtl/mmu_slot_regs.sv
module mmu_slot_regs #(
  parameter int NSLOT = 8,
  parameter int IDX_W = 3,
  parameter int BLK_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            widx_i,
  input  logic [BLK_W-1:0]            wdata_i,
  output logic [NSLOT-1:0][BLK_W-1:0] slots_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slots_o[g] <= BLK_W'(g);
      else if (we_i && widx_i == IDX_W'(g))      slots_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter int LOG_AW = 16,
  parameter int IDX_W  = 3,
  parameter int BLK_W  = 8,
  parameter int NSLOT  = 1 << IDX_W,
  localparam int OFF_W = LOG_AW - IDX_W,
  localparam int PHYS_AW = BLK_W + OFF_W
) (
  input  logic [LOG_AW-1:0]           addr_i,
  input  logic [NSLOT-1:0][BLK_W-1:0] slots_i,
  output logic [PHYS_AW-1:0]          phys_addr_o
);
  logic [IDX_W-1:0] slot_idx;
  assign slot_idx    = addr_i[LOG_AW-1 -: IDX_W];
  assign phys_addr_o = {slots_i[slot_idx], addr_i[OFF_W-1:0]};
endmodule

// File: rtl/mmu_region_dec.sv
module mmu_region_dec
  import mmu_pkg::*;
#(
  parameter int BLK_W     = 8,
  parameter int RAM_END   = 64,
  parameter int FLASH_END = 128,
  parameter int EXP_END   = 160
) (
  input  logic [BLK_W-1:0] blk_i,
  output region_e          region_o
);
  int unsigned blk;
  always_comb begin
    blk = int'(blk_i);
    if (blk < RAM_END)        region_o = RGN_RAM;
    else if (blk < FLASH_END) region_o = RGN_FLASH;
    else if (blk < EXP_END)   region_o = RGN_EXP;
    else                      region_o = RGN_RSVD;
  end
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import mmu_pkg::*;
#(
  parameter int LOG_AW    = 16,
  parameter int IDX_W     = 3,
  parameter int BLK_W     = 8,
  parameter int DATA_W    = 8,
  parameter logic [LOG_AW-1:0] REG_BASE = 16'h0008,
  parameter int RAM_END   = 64,
  parameter int FLASH_END = 128,
  parameter int EXP_END   = 160,
  localparam int NSLOT    = 1 << IDX_W,
  localparam int PHYS_AW  = BLK_W + LOG_AW - IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LOG_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [PHYS_AW-1:0] phys_addr_o,
  output logic               ram_sel_o,
  output logic               flash_sel_o,
  output logic               exp_sel_o,
  output logic               ram_we_o,
  output logic               flash_we_o,
  output logic               exp_we_o,
  output logic               rsvd_o,
  output logic               reg_hit_o
);
  logic [NSLOT-1:0][BLK_W-1:0] slots;
  logic                        in_win, access, mem_acc;
  logic [IDX_W-1:0]            ridx;
  region_e                     region;

  // register window is NSLOT-aligned
  assign in_win  = addr_i[LOG_AW-1:IDX_W] == REG_BASE[LOG_AW-1:IDX_W];
  assign ridx    = addr_i[IDX_W-1:0];
  assign access  = rd_i | wr_i;
  assign mem_acc = access & ~in_win;

  mmu_slot_regs #(.NSLOT(NSLOT), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i & in_win),
    .widx_i  (ridx),
    .wdata_i (wdata_i[BLK_W-1:0]),
    .slots_o (slots)
  );

  mmu_xlate #(.LOG_AW(LOG_AW), .IDX_W(IDX_W), .BLK_W(BLK_W), .NSLOT(NSLOT)) u_xlate (
    .addr_i      (addr_i),
    .slots_i     (slots),
    .phys_addr_o (phys_addr_o)
  );

  mmu_region_dec #(
    .BLK_W(BLK_W), .RAM_END(RAM_END), .FLASH_END(FLASH_END), .EXP_END(EXP_END)
  ) u_dec (
    .blk_i    (phys_addr_o[PHYS_AW-1 -: BLK_W]),
    .region_o (region)
  );

  assign reg_hit_o   = access & in_win;
  assign ram_sel_o   = mem_acc & (region == RGN_RAM);
  assign flash_sel_o = mem_acc & (region == RGN_FLASH);
  assign exp_sel_o   = mem_acc & (region == RGN_EXP);
  assign rsvd_o      = mem_acc & (region == RGN_RSVD);
  assign ram_we_o    = ram_sel_o & wr_i;
  assign flash_we_o  = flash_sel_o & wr_i;
  assign exp_we_o    = exp_sel_o & wr_i;

  always_comb begin
    if (in_win)                 rdata_o = DATA_W'(slots[ridx]);
    else if (region == RGN_RSVD) rdata_o = '1;
    else                        rdata_o = mem_rdata_i;
  end
endmodule

// File: rtl/mmu_chk.sv
module mmu_chk #(
  parameter int LOG_AW  = 16,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 8,
  parameter int PHYS_AW = 21,
  parameter logic [LOG_AW-1:0] REG_BASE = 16'h0008
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [LOG_AW-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  mem_rdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [PHYS_AW-1:0] phys_addr_o,
  input logic               ram_sel_o,
  input logic               flash_sel_o,
  input logic               exp_sel_o,
  input logic               ram_we_o,
  input logic               flash_we_o,
  input logic               exp_we_o,
  input logic               rsvd_o,
  input logic               reg_hit_o
);
  localparam int OFF_W = LOG_AW - IDX_W;
  localparam int BLK_W = PHYS_AW - OFF_W;
  logic win;
  assign win = addr_i[LOG_AW-1:IDX_W] == REG_BASE[LOG_AW-1:IDX_W];

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[OFF_W-1:0] == addr_i[OFF_W-1:0]);

  // R3
  remap_next_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && win) |=> (addr_i[LOG_AW-1 -: IDX_W] != $past(addr_i[IDX_W-1:0]) ||
                       phys_addr_o[PHYS_AW-1 -: BLK_W] == $past(wdata_i[BLK_W-1:0])));

  // R4
  reg_window_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && win) |-> (reg_hit_o && !ram_sel_o && !flash_sel_o && !exp_sel_o &&
                                 !rsvd_o && !ram_we_o && !flash_we_o && !exp_we_o));

  // R7
  rsvd_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> (!ram_sel_o && !flash_sel_o && !exp_sel_o && (!rd_i || rdata_o == '1)));

  // R8
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_sel_o, flash_sel_o, exp_sel_o, rsvd_o}));

  // R8
  strobe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o || flash_we_o || exp_we_o) |->
      (wr_i && (!ram_we_o || ram_sel_o) && (!flash_we_o || flash_sel_o) && (!exp_we_o || exp_sel_o)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> $countones({ram_sel_o, flash_sel_o, exp_sel_o, rsvd_o, reg_hit_o,
                                      ram_we_o, flash_we_o, exp_we_o}) == 0);

  // R10
  mem_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (ram_sel_o || flash_sel_o || exp_sel_o)) |-> rdata_o == mem_rdata_i);
endmodule

bind bank_mmu mmu_chk #(
  .LOG_AW(LOG_AW), .IDX_W(IDX_W), .DATA_W(DATA_W), .PHYS_AW(PHYS_AW), .REG_BASE(REG_BASE)
) u_chk (.*);

// File: tb/sim_bank_mmu.sv
`timescale 1ns/1ps
module sim_bank_mmu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;
  logic [7:0]  rdata_o;
  logic [20:0] phys_addr_o;
  logic        ram_sel_o, flash_sel_o, exp_sel_o;
  logic        ram_we_o, flash_we_o, exp_we_o, rsvd_o, reg_hit_o;

  int tests = 0, fails = 0;
  logic [7:0] model [8];
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  bank_mmu u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, expv);
    end
  endtask

  function automatic int rgn(input logic [7:0] b);
    if (b < 8'h40) return 0;
    if (b < 8'h80) return 1;
    if (b < 8'hA0) return 2;
    return 3;
  endfunction

  task automatic access(input logic [15:0] a, input bit rd, input bit wr,
                        input logic [7:0] wd, input logic [7:0] md);
    bit win, acc;
    logic [7:0] blk, erd;
    logic [20:0] ephys;
    logic [2:0] esel, ewe;
    int r;
    string req;
    @(negedge clk_i);
    addr_i = a; rd_i = rd; wr_i = wr; wdata_i = wd; mem_rdata_i = md;
    #1;
    win   = (a[15:3] == 13'h0001);
    acc   = rd | wr;
    blk   = model[a[15:13]];
    ephys = {blk, a[12:0]};
    r     = rgn(blk);
    esel  = '0;
    if (acc && !win && r < 3) esel[r] = 1'b1;
    ewe   = wr ? esel : 3'b000;
    erd   = win ? model[a[2:0]] : (r == 3 ? 8'hFF : md);
    req   = win ? "R4" : (!acc ? "R9" : (r == 3 ? "R7" : (r == 0 ? "R5" : "R6")));
    chk(phys_addr_o == ephys, "R2", "phys", 32'(phys_addr_o), 32'(ephys));
    chk({exp_sel_o, flash_sel_o, ram_sel_o} == esel, req, "sel",
        32'({exp_sel_o, flash_sel_o, ram_sel_o}), 32'(esel));
    chk({exp_we_o, flash_we_o, ram_we_o} == ewe, "R8", "we",
        32'({exp_we_o, flash_we_o, ram_we_o}), 32'(ewe));
    chk(rsvd_o == (acc && !win && r == 3), req, "rsvd", 32'(rsvd_o), 32'(acc && !win && r == 3));
    chk(reg_hit_o == (acc && win), req, "reg_hit", 32'(reg_hit_o), 32'(acc && win));
    if (rd)
      chk(rdata_o == erd, win ? "R3" : (r == 3 ? "R7" : "R10"), "rdata",
          32'(rdata_o), 32'(erd));
    if (wr && win) model[a[2:0]] = wd;  // lands at the coming edge
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) model[i] = 8'(i);
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state: identity map
    chk(phys_addr_o == 21'h0, "R1", "phys@reset", 32'(phys_addr_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int n = 0; n < 8; n++) begin
      logic [15:0] a;
      a = 16'((n << 13) | 16'h0123);
      access(a, 1'b1, 1'b0, 8'h00, 8'h5A);
      chk(phys_addr_o == {5'b0, a}, "R1", "identity", 32'(phys_addr_o), 32'(a));
      access(16'(16'h0008 + n), 1'b1, 1'b0, 8'h00, 8'h00);
      chk(rdata_o == 8'(n), "R1", "reg reset value", 32'(rdata_o), n);
    end
    // boundaries R5/R6/R7 and strobe R8
    access(16'h000A, 1'b0, 1'b1, 8'h40, 8'h00);   // window 2 -> first flash block
    access(16'h4ABC, 1'b0, 1'b1, 8'h00, 8'h00);
    access(16'h000B, 1'b0, 1'b1, 8'h3F, 8'h00);   // window 3 -> last RAM block
    access(16'h7FFF, 1'b1, 1'b0, 8'h00, 8'hC3);
    access(16'h000C, 1'b0, 1'b1, 8'h9F, 8'h00);   // window 4 -> last expansion block
    access(16'h8001, 1'b0, 1'b1, 8'h00, 8'h00);
    access(16'h000D, 1'b0, 1'b1, 8'hA0, 8'h00);   // window 5 -> first reserved block
    access(16'hA555, 1'b1, 1'b0, 8'h00, 8'h11);
    access(16'hA556, 1'b0, 1'b1, 8'h00, 8'h00);
    access(16'h000E, 1'b0, 1'b1, 8'h80, 8'h00);   // window 6 -> first expansion block
    access(16'hC000, 1'b1, 1'b0, 8'h00, 8'h77);
    access(16'h000F, 1'b0, 1'b1, 8'h7F, 8'h00);   // window 7 -> last flash block
    access(16'hFFFF, 1'b0, 1'b1, 8'h00, 8'h00);
    // R4 window 0 neighbours of the register window
    access(16'h0008, 1'b0, 1'b1, 8'hFF, 8'h00);
    access(16'h0007, 1'b1, 1'b0, 8'h00, 8'h42);   // reserved now, not a register
    access(16'h0010, 1'b0, 1'b1, 8'h00, 8'h00);
    access(16'h0008, 1'b1, 1'b0, 8'h00, 8'h00);
    access(16'h0008, 1'b0, 1'b1, 8'h00, 8'h00);
    // R9 idle
    access(16'h2000, 1'b0, 1'b0, 8'h00, 8'h00);
    access(16'h000C, 1'b0, 1'b0, 8'h55, 8'h00);
    access(16'h8000, 1'b1, 1'b0, 8'h00, 8'h99);   // idle write was ignored
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [1:0]  op;
      a  = 16'($urandom);
      if ($urandom_range(3) == 0) a = 16'(16'h0008 + $urandom_range(7));
      op = 2'($urandom_range(3));
      access(a, op == 2'd1, op >= 2'd2, 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end
endmodule